// File: doc/BRIEF.md
# Serial Link Out-of-Band Burst Detector and Generator

This block sits below the physical layer of a serial storage link and handles the out-of-band signalling used to bring the link up. The receive half watches a per-cycle "burst present" flag from an abstracted squelch circuit. It measures the quiet time that precedes each burst, and gives a one-cycle pulse when a reset/init pattern or a wake pattern has been recognised. The two patterns are told apart only by the length of their gaps. The reset/init pattern is the same electrically whichever end sends it, so one receiver output serves both meanings.

The transmit half takes a one-cycle request for either pattern. It drives a burst-enable output with the required number of bursts, burst width and gap width. After a reset/init pattern it also holds the line quiet for a trailing interval. All timing is counted in reference clock cycles, and every interval is a parameter. The defaults model a 106.7 ns burst as 8 cycles, the 320 ns reset gap as 24 cycles, the 175 ns and 525 ns gap limits as 13 and 39 cycles, and a short wake gap of 8 cycles accepted from 5 to 11 cycles.

Top module: `oob_link_sig`

## Requirements
- R1: While reset is held and on the first cycle after it, both detect outputs, the burst-enable output and the busy output are 0.
- R2: A gap is the count of consecutive low cycles on the burst input before a rising edge. When four consecutive bursts are separated by gaps inside the reset window (13 to 39 cycles inclusive), the reset detect output is 1 for exactly the cycle after the fourth burst's first high cycle. A gap of 12 or 40 does not qualify.
- R3: When four consecutive bursts are separated by gaps inside the wake window (5 to 11 cycles inclusive), the wake detect output pulses in the same way. A gap of 4 or 12 does not qualify.
- R4: A gap outside both windows, or a gap whose window differs from the earlier gaps of the run, restarts the count, and the burst after it becomes the first of a new run.
- R5: Each detect pulse lasts one cycle. After a detection, further bursts are ignored until a gap of 40 or more cycles is seen, whatever their spacing.
- R6: The gap counter saturates. An idle of any length, including 88 cycles, counts as a long gap and never as a valid spacing.
- R7: A reset request gives exactly 6 bursts of 8 high cycles with 24-cycle gaps, then 40 quiet cycles with busy still 1, then busy falls.
- R8: A wake request gives exactly 6 bursts of 8 high cycles with 8-cycle gaps, and busy falls on the cycle after the last burst ends.
- R9: Requests that arrive while busy is 1 are ignored. If both requests arrive in the same idle cycle, the reset pattern is sent.
- R10: A pattern from the generator, fed back into the receiver, is recognised as the matching pattern and never as the other one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_burst_i | input | 1 | Squelch flag, 1 while a burst is present on the line |
| tx_rst_req_i | input | 1 | Request to send the reset/init pattern |
| tx_wake_req_i | input | 1 | Request to send the wake pattern |
| rx_rst_det_o | output | 1 | One-cycle pulse: reset/init pattern recognised |
| rx_wake_det_o | output | 1 | One-cycle pulse: wake pattern recognised |
| tx_burst_o | output | 1 | Burst enable for the transmitter |
| tx_busy_o | output | 1 | Generator is sending a pattern or its trailing quiet time |

## Verification
A wrong run count or pattern kind in the receiver shows up on the detect outputs at the leading edge of the fourth burst: the pulse is missing, comes early, or appears on the wrong output. A counter that wraps, or a disarm flag that clears too early, shows up as an extra pulse within one pattern after the bad gap. In the generator, a wrong cycle counter or burst counter changes the measured width of a burst or a gap, or the length of the quiet tail, within one interval of the fault. The gap sweep crosses every boundary of both windows, so an off-by-one at any limit makes that gap value's pulse count wrong.

// File: rtl/oob_pkg.sv
package oob_pkg;
    timeunit 1ns;
    timeprecision 100ps;

    typedef enum logic [1:0] {
        PAT_NONE = 2'd0,
        PAT_RST  = 2'd1,
        PAT_WAKE = 2'd2
    } oob_pat_e;

    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,
        TX_BURST = 2'd1,
        TX_GAP   = 2'd2,
        TX_QUIET = 2'd3
    } oob_tx_st_e;
endpackage

// File: rtl/oob_rx_classify.sv
module oob_rx_classify
    import oob_pkg::*;
#(
    parameter int RST_GAP_MIN  = 13,
    parameter int RST_GAP_MAX  = 39,
    parameter int WAKE_GAP_MIN = 5,
    parameter int WAKE_GAP_MAX = 11,
    parameter int DET_BURSTS   = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic burst_i,
    output logic rst_det_o,
    output logic wake_det_o
);
    timeunit 1ns;
    timeprecision 100ps;

    // any gap at or above SAT is "long": it re-arms and starts a run
    localparam int SAT_I = ((RST_GAP_MAX > WAKE_GAP_MAX) ? RST_GAP_MAX : WAKE_GAP_MAX) + 1;
    localparam int GAP_W = $clog2(SAT_I + 1);
    localparam int RUN_W = $clog2(DET_BURSTS + 1);

    localparam logic [GAP_W-1:0] SAT    = GAP_W'(SAT_I);
    localparam logic [GAP_W-1:0] R_MIN  = GAP_W'(RST_GAP_MIN);
    localparam logic [GAP_W-1:0] R_MAX  = GAP_W'(RST_GAP_MAX);
    localparam logic [GAP_W-1:0] W_MIN  = GAP_W'(WAKE_GAP_MIN);
    localparam logic [GAP_W-1:0] W_MAX  = GAP_W'(WAKE_GAP_MAX);
    localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(DET_BURSTS - 1);

    typedef struct packed {
        logic             prev;
        logic [GAP_W-1:0] gap;
        logic [RUN_W-1:0] run;
        oob_pat_e         kind;
        logic             armed;
        logic             det_rst;
        logic             det_wake;
    } rx_st_t;

    rx_st_t q, d;

    logic rise;
    logic gap_long;
    logic gap_rst;
    logic gap_wake;

    assign rise     = burst_i && !q.prev;
    assign gap_long = (q.gap >= SAT);
    assign gap_rst  = (q.gap >= R_MIN) && (q.gap <= R_MAX);
    assign gap_wake = (q.gap >= W_MIN) && (q.gap <= W_MAX);

    always_comb begin
        d          = q;
        d.prev     = burst_i;
        d.det_rst  = 1'b0;
        d.det_wake = 1'b0;

        if (burst_i) begin
            d.gap = '0;
        end else if (!gap_long) begin
            d.gap = q.gap + 1'b1;
        end

        if (rise) begin
            if (gap_long) begin
                d.armed = 1'b1;
                d.run   = RUN_W'(1);
                d.kind  = PAT_NONE;
            end else if (q.armed) begin
                if (gap_rst && q.kind != PAT_WAKE) begin
                    d.kind = PAT_RST;
                    if (q.run == RUN_LAST) begin
                        d.det_rst = 1'b1;
                        d.armed   = 1'b0;
                        d.run     = '0;
                    end else begin
                        d.run = q.run + 1'b1;
                    end
                end else if (gap_wake && q.kind != PAT_RST) begin
                    d.kind = PAT_WAKE;
                    if (q.run == RUN_LAST) begin
                        d.det_wake = 1'b1;
                        d.armed    = 1'b0;
                        d.run      = '0;
                    end else begin
                        d.run = q.run + 1'b1;
                    end
                end else begin
                    d.run  = RUN_W'(1);
                    d.kind = PAT_NONE;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.prev     <= 1'b0;
            q.gap      <= SAT;
            q.run      <= '0;
            q.kind     <= PAT_NONE;
            q.armed    <= 1'b0;
            q.det_rst  <= 1'b0;
            q.det_wake <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign rst_det_o  = q.det_rst;
    assign wake_det_o = q.det_wake;

    a_r5_rst_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        rst_det_o |=> !rst_det_o);
    a_r5_wake_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        wake_det_o |=> !wake_det_o);
    a_r5_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(rst_det_o && wake_det_o));
    a_r6_gap_saturates: assert property (@(posedge clk) disable iff (!rst_n)
        q.gap <= SAT);
    a_r2_rst_window: assert property (@(posedge clk) disable iff (!rst_n)
        rst_det_o |-> ($past(q.gap) >= R_MIN && $past(q.gap) <= R_MAX));
    a_r3_wake_window: assert property (@(posedge clk) disable iff (!rst_n)
        wake_det_o |-> ($past(q.gap) >= W_MIN && $past(q.gap) <= W_MAX));
    a_r2_on_leading_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_det_o || wake_det_o) |-> ($past(burst_i) && !$past(q.prev)));
endmodule

// File: rtl/oob_tx_gen.sv
module oob_tx_gen
    import oob_pkg::*;
#(
    parameter int BURST_CYC      = 8,
    parameter int RST_GAP_CYC    = 24,
    parameter int WAKE_GAP_CYC   = 8,
    parameter int QUIET_CYC      = 40,
    parameter int TX_RST_BURSTS  = 6,
    parameter int TX_WAKE_BURSTS = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rst_req_i,
    input  logic wake_req_i,
    output logic burst_o,
    output logic busy_o
);
    timeunit 1ns;
    timeprecision 100ps;

    localparam int M1    = (BURST_CYC > QUIET_CYC) ? BURST_CYC : QUIET_CYC;
    localparam int M2    = (RST_GAP_CYC > WAKE_GAP_CYC) ? RST_GAP_CYC : WAKE_GAP_CYC;
    localparam int CMAX  = (M1 > M2) ? M1 : M2;
    localparam int CNT_W = $clog2(CMAX + 1);
    localparam int BMAX  = (TX_RST_BURSTS > TX_WAKE_BURSTS) ? TX_RST_BURSTS : TX_WAKE_BURSTS;
    localparam int BN_W  = $clog2(BMAX + 1);

    localparam logic [CNT_W-1:0] BURST_LD = CNT_W'(BURST_CYC - 1);
    localparam logic [CNT_W-1:0] RGAP_LD  = CNT_W'(RST_GAP_CYC - 1);
    localparam logic [CNT_W-1:0] WGAP_LD  = CNT_W'(WAKE_GAP_CYC - 1);
    localparam logic [CNT_W-1:0] QUIET_LD = CNT_W'(QUIET_CYC - 1);
    localparam logic [BN_W-1:0]  RST_LEFT = BN_W'(TX_RST_BURSTS - 1);
    localparam logic [BN_W-1:0]  WAK_LEFT = BN_W'(TX_WAKE_BURSTS - 1);

    typedef struct packed {
        oob_tx_st_e       st;
        logic [CNT_W-1:0] cnt;
        logic [BN_W-1:0]  left;
        logic             is_rst;
    } tx_st_t;

    tx_st_t q, d;

    always_comb begin
        d = q;
        unique case (q.st)
            TX_IDLE: begin
                if (rst_req_i) begin
                    d.st     = TX_BURST;
                    d.cnt    = BURST_LD;
                    d.left   = RST_LEFT;
                    d.is_rst = 1'b1;
                end else if (wake_req_i) begin
                    d.st     = TX_BURST;
                    d.cnt    = BURST_LD;
                    d.left   = WAK_LEFT;
                    d.is_rst = 1'b0;
                end
            end
            TX_BURST: begin
                if (q.cnt != '0) begin
                    d.cnt = q.cnt - 1'b1;
                end else if (q.left != '0) begin
                    d.st  = TX_GAP;
                    d.cnt = q.is_rst ? RGAP_LD : WGAP_LD;
                end else if (q.is_rst) begin
                    d.st  = TX_QUIET;
                    d.cnt = QUIET_LD;
                end else begin
                    d.st = TX_IDLE;
                end
            end
            TX_GAP: begin
                if (q.cnt != '0) begin
                    d.cnt = q.cnt - 1'b1;
                end else begin
                    d.st   = TX_BURST;
                    d.cnt  = BURST_LD;
                    d.left = q.left - 1'b1;
                end
            end
            TX_QUIET: begin
                if (q.cnt != '0) begin
                    d.cnt = q.cnt - 1'b1;
                end else begin
                    d.st = TX_IDLE;
                end
            end
            default: d.st = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st     <= TX_IDLE;
            q.cnt    <= '0;
            q.left   <= '0;
            q.is_rst <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign burst_o = (q.st == TX_BURST);
    assign busy_o  = (q.st != TX_IDLE);

    a_r9_burst_inside_busy: assert property (@(posedge clk) disable iff (!rst_n)
        burst_o |-> busy_o);
    a_r7_starts_with_burst: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> burst_o);
    a_r7_quiet_only_after_rst: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == TX_QUIET) |-> (q.is_rst && !burst_o));
    a_r9_kind_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(q.is_rst));
    a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        q.left < BN_W'(BMAX));
endmodule

// File: rtl/oob_link_sig.sv
module oob_link_sig #(
    parameter int BURST_CYC      = 8,
    parameter int RST_GAP_CYC    = 24,
    parameter int WAKE_GAP_CYC   = 8,
    parameter int RST_GAP_MIN    = 13,
    parameter int RST_GAP_MAX    = 39,
    parameter int WAKE_GAP_MIN   = 5,
    parameter int WAKE_GAP_MAX   = 11,
    parameter int QUIET_CYC      = 40,
    parameter int DET_BURSTS     = 4,
    parameter int TX_RST_BURSTS  = 6,
    parameter int TX_WAKE_BURSTS = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_burst_i,
    input  logic tx_rst_req_i,
    input  logic tx_wake_req_i,
    output logic rx_rst_det_o,
    output logic rx_wake_det_o,
    output logic tx_burst_o,
    output logic tx_busy_o
);
    timeunit 1ns;
    timeprecision 100ps;

    oob_rx_classify #(
        .RST_GAP_MIN (RST_GAP_MIN),
        .RST_GAP_MAX (RST_GAP_MAX),
        .WAKE_GAP_MIN(WAKE_GAP_MIN),
        .WAKE_GAP_MAX(WAKE_GAP_MAX),
        .DET_BURSTS  (DET_BURSTS)
    ) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .burst_i   (rx_burst_i),
        .rst_det_o (rx_rst_det_o),
        .wake_det_o(rx_wake_det_o)
    );

    oob_tx_gen #(
        .BURST_CYC     (BURST_CYC),
        .RST_GAP_CYC   (RST_GAP_CYC),
        .WAKE_GAP_CYC  (WAKE_GAP_CYC),
        .QUIET_CYC     (QUIET_CYC),
        .TX_RST_BURSTS (TX_RST_BURSTS),
        .TX_WAKE_BURSTS(TX_WAKE_BURSTS)
    ) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .rst_req_i (tx_rst_req_i),
        .wake_req_i(tx_wake_req_i),
        .burst_o   (tx_burst_o),
        .busy_o    (tx_busy_o)
    );
endmodule

// File: tb/oob_link_sig_tb.sv
module oob_link_sig_tb;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int BL = 8;
    localparam int RG = 24;
    localparam int WG = 8;
    localparam int QT = 40;
    localparam int NB = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic stim = 1'b0;
    logic loop_sel = 1'b0;
    logic rreq = 1'b0;
    logic wreq = 1'b0;
    logic rx_in;
    logic rdet, wdet, txb, busy;

    int n_chk = 0;
    int n_fail = 0;
    int n_rst = 0;
    int n_wake = 0;
    int n_txhi = 0;
    bit last_r = 1'b0;
    bit last_w = 1'b0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    assign rx_in = loop_sel ? txb : stim;

    oob_link_sig u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .rx_burst_i   (rx_in),
        .tx_rst_req_i (rreq),
        .tx_wake_req_i(wreq),
        .rx_rst_det_o (rdet),
        .rx_wake_det_o(wdet),
        .tx_burst_o   (txb),
        .tx_busy_o    (busy)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (rdet) begin
                n_rst++;
                check(!last_r, "R5 reset pulse width", 2, 1);
            end
            if (wdet) begin
                n_wake++;
                check(!last_w, "R5 wake pulse width", 2, 1);
            end
            if (txb) n_txhi++;
            last_r = rdet;
            last_w = wdet;
        end
    end

    task automatic burst(input int len);
        stim = 1'b1;
        repeat (len) @(negedge clk);
        stim = 1'b0;
    endtask

    task automatic quiet(input int len);
        stim = 1'b0;
        repeat (len) @(negedge clk);
    endtask

    task automatic send_run(input int n, input int g);
        for (int i = 0; i < n; i++) begin
            if (i > 0) quiet(g);
            burst(BL);
        end
    endtask

    task automatic measure(input int exp_gap, output int nb, output int bad, output int trail);
        int hi;
        int lo;
        nb = 0; bad = 0; trail = -1; hi = 0; lo = 0;
        for (int k = 0; k < 3000; k++) begin
            if (!busy) begin
                if (hi > 0) begin
                    nb++;
                    if (hi != BL) bad++;
                    trail = 0;
                end else begin
                    trail = lo;
                end
                break;
            end
            if (txb) begin
                if (lo > 0) begin
                    if (lo != exp_gap) bad++;
                    lo = 0;
                end
                hi++;
            end else begin
                if (hi > 0) begin
                    nb++;
                    if (hi != BL) bad++;
                    hi = 0;
                end
                lo++;
            end
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int br, bw, nb, bad, trail;
        repeat (4) @(negedge clk);
        check({rdet, wdet, txb, busy} == 4'b0, "R1 outputs in reset", int'({rdet, wdet, txb, busy}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check({rdet, wdet, txb, busy} == 4'b0, "R1 outputs after reset", int'({rdet, wdet, txb, busy}), 0);

        // R2 R3 R4: sweep every gap length across both windows
        for (int g = 1; g <= 44; g++) begin
            quiet(50);
            br = n_rst; bw = n_wake;
            send_run(4, g);
            quiet(3);
            check(n_rst - br == ((g >= 13 && g <= 39) ? 1 : 0), $sformatf("R2 sweep gap %0d", g),
                  n_rst - br, (g >= 13 && g <= 39) ? 1 : 0);
            check(n_wake - bw == ((g >= 5 && g <= 11) ? 1 : 0), $sformatf("R3 sweep gap %0d", g),
                  n_wake - bw, (g >= 5 && g <= 11) ? 1 : 0);
        end

        // R2: pulse timing on the fourth burst's leading edge
        quiet(50);
        send_run(3, RG);
        quiet(RG);
        stim = 1'b1;
        @(negedge clk);
        check(rdet == 1'b1, "R2 pulse after fourth leading edge", int'(rdet), 1);
        @(negedge clk);
        check(rdet == 1'b0, "R2 pulse ends", int'(rdet), 0);
        repeat (BL - 2) @(negedge clk);
        stim = 1'b0;

        // R4: window change restarts the run
        quiet(50);
        br = n_rst; bw = n_wake;
        burst(BL); quiet(RG); burst(BL); quiet(WG); burst(BL); quiet(RG); burst(BL); quiet(RG); burst(BL);
        quiet(3);
        check(n_rst == br && n_wake == bw, "R4 mixed gaps restart", n_rst - br + n_wake - bw, 0);
        quiet(RG - 3); burst(BL); quiet(3);
        check(n_rst - br == 1, "R4 new run completes", n_rst - br, 1);

        // R5: disarmed after detection until a long gap
        quiet(50);
        br = n_rst;
        send_run(8, RG);
        quiet(3);
        check(n_rst - br == 1, "R5 bursts after detection ignored", n_rst - br, 1);
        quiet(9);
        send_run(4, RG);
        quiet(3);
        check(n_rst - br == 1, "R5 short gap does not re-arm", n_rst - br, 1);
        quiet(50);
        send_run(4, RG);
        quiet(3);
        check(n_rst - br == 2, "R5 long gap re-arms", n_rst - br, 2);

        // R6: 88-cycle idle must not alias to a valid 24-cycle gap
        quiet(50);
        br = n_rst;
        burst(BL); quiet(88); send_run(3, RG);
        quiet(3);
        check(n_rst == br, "R6 long idle not a valid gap", n_rst - br, 0);
        quiet(RG - 3); burst(BL); quiet(3);
        check(n_rst - br == 1, "R6 long idle starts run", n_rst - br, 1);

        // R7 R10: reset pattern, looped back
        quiet(50);
        loop_sel = 1'b1;
        br = n_rst; bw = n_wake;
        rreq = 1'b1; @(negedge clk); rreq = 1'b0;
        measure(RG, nb, bad, trail);
        check(nb == NB, "R7 reset burst count", nb, NB);
        check(bad == 0, "R7 reset burst and gap widths", bad, 0);
        check(trail == QT, "R7 quiet tail", trail, QT);
        check(n_rst - br == 1 && n_wake == bw, "R10 reset loopback", n_rst - br, 1);

        // R8 R10: wake pattern
        quiet(50);
        br = n_rst; bw = n_wake;
        wreq = 1'b1; @(negedge clk); wreq = 1'b0;
        measure(WG, nb, bad, trail);
        check(nb == NB, "R8 wake burst count", nb, NB);
        check(bad == 0, "R8 wake burst and gap widths", bad, 0);
        check(trail == 0, "R8 no quiet tail", trail, 0);
        check(n_wake - bw == 1 && n_rst == br, "R10 wake loopback", n_wake - bw, 1);

        // R9: request while busy ignored
        quiet(50);
        rreq = 1'b1; @(negedge clk); rreq = 1'b0;
        fork
            measure(RG, nb, bad, trail);
            begin
                repeat (30) @(negedge clk);
                wreq = 1'b1; @(negedge clk); wreq = 1'b0;
            end
        join
        check(nb == NB && bad == 0 && trail == QT, "R9 busy request ignored", nb, NB);
        br = n_txhi;
        quiet(20);
        check(n_txhi == br, "R9 nothing sent afterwards", n_txhi - br, 0);

        // R9: simultaneous requests pick reset
        rreq = 1'b1; wreq = 1'b1; @(negedge clk); rreq = 1'b0; wreq = 1'b0;
        measure(RG, nb, bad, trail);
        check(nb == NB && bad == 0, "R9 priority pattern shape", bad, 0);
        check(trail == QT, "R9 reset wins", trail, QT);

        loop_sel = 1'b0;
        quiet(5);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule